// File: doc/BRIEF.md
# Inter-Processor Interrupt Unit

This block lets any core of a multicore cluster raise an interrupt on any core, itself included, through one shared command port. Each cycle at most one command is accepted. The command carries three fields: the identity of the issuing core, an operation code, and a core-index argument. The operations are:

- read the pending status toward a target;
- raise an interrupt on a target;
- ask which cores have interrupts pending toward the caller;
- acknowledge one sender.

The result lands in a readback register one cycle after the command strobe.

The state is a square matrix of pending bits, one bit for each sender/target pair. Each target row is the bitmask of senders waiting on that target. The row is OR-reduced onto the target's single interrupt line, so raises from several senders to one target merge into one asserted line. The handler asks for the sender bitmask and then acknowledges the senders one at a time. A sender is expected to poll the status of a pair until it reads zero before it raises that pair again; a raise on a pair that is still pending is absorbed.

Top module: `ipi_unit`

## Requirements
- R1: After reset all pending bits are clear, every `irq_out` bit is low and `rb_data` is zero.
- R2: A raise command (op 2'b01) from core C with argument T sets pending bit C→T. `irq_out[T]` is high in the cycle after the strobe.
- R3: A status command (op 2'b00) from core C with argument T loads `rb_data` with bit 0 equal to pending bit C→T and all other bits zero, valid in the cycle after the strobe.
- R4: A source command (op 2'b10) from core C loads `rb_data` with the sender bitmask of target C, where bit S is pending bit S→C, valid in the cycle after the strobe.
- R5: An acknowledge command (op 2'b11) from core C with argument S clears only pending bit S→C. Acknowledging a bit that is not set changes nothing.
- R6: `irq_out[T]` is high exactly while any bit of target T's sender bitmask is set. It drops in the cycle after the last bit is acknowledged.
- R7: Pending raises from several senders to one target share one asserted line, and the source readback then shows several bits.
- R8: A raise aimed at a pair whose bit is already set leaves the bit set and has no other effect.
- R9: A core may raise an interrupt on itself. The self pair behaves like any other pair.
- R10: Raise and acknowledge commands load `rb_data` with zero. Without a strobe, `rb_data` keeps its value.
- R11: While `cmd_valid` is low, no pending bit and no `irq_out` bit changes, whatever the other command inputs carry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_valid | input | 1 | Command strobe, one command per cycle |
| cmd_core | input | ID_W | Index of the issuing core |
| cmd_op | input | 2 | Operation code: 00 status, 01 raise, 10 source, 11 acknowledge |
| cmd_arg | input | ID_W | Target core (status, raise) or sender core (acknowledge) |
| rb_data | output | NUM_CORES | Readback register |
| irq_out | output | NUM_CORES | One interrupt line per core |

## Verification
The assertions assume three things about the inputs:

- `cmd_core` and `cmd_arg` always name existing cores.
- The command fields are meaningful only while `cmd_valid` is high.
- Only one command is presented per cycle, because there is one port.

With the default four cores every index code is a legal core, so both index fields may carry any value. The bench drives every combination of issuer, operation and argument, plus deliberately repeated raises to pending pairs. While the strobe is low it puts arbitrary values on the idle command fields, to show that they are ignored.

// File: rtl/ipi_pkg.sv
package ipi_pkg;

   typedef enum logic [1:0] {
      IPI_OP_STATUS  = 2'b00,
      IPI_OP_RAISE   = 2'b01,
      IPI_OP_SOURCES = 2'b10,
      IPI_OP_ACK     = 2'b11
   } ipi_op_e;

endpackage

// File: rtl/ipi_pend_matrix.sv
module ipi_pend_matrix #(
   parameter int NUM_CORES = 4,
   parameter int ID_W      = (NUM_CORES > 1) ? $clog2(NUM_CORES) : 1,
   localparam int CELLS    = NUM_CORES * NUM_CORES
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             set_en,
   input  logic [ID_W-1:0]  set_sender,
   input  logic [ID_W-1:0]  set_target,
   input  logic             clr_en,
   input  logic [ID_W-1:0]  clr_sender,
   input  logic [ID_W-1:0]  clr_target,
   output logic [CELLS-1:0] pend
);

   // cell index is target*NUM_CORES + sender
   for (genvar t = 0; t < NUM_CORES; t++) begin : g_tgt
      for (genvar s = 0; s < NUM_CORES; s++) begin : g_snd
         logic hit_set, hit_clr;
         assign hit_set = set_en && (set_sender == ID_W'(s)) && (set_target == ID_W'(t));
         assign hit_clr = clr_en && (clr_sender == ID_W'(s)) && (clr_target == ID_W'(t));

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)       pend[t*NUM_CORES+s] <= 1'b0;
            else if (hit_set) pend[t*NUM_CORES+s] <= 1'b1;
            else if (hit_clr) pend[t*NUM_CORES+s] <= 1'b0;
         end

         // R2
         pend_rise_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(pend[t*NUM_CORES+s]) |-> $past(set_en && set_sender == ID_W'(s)
                                                 && set_target == ID_W'(t)));
         // R5
         pend_ack_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (clr_en && clr_sender == ID_W'(s) && clr_target == ID_W'(t)) |=> !pend[t*NUM_CORES+s]);
         // R8
         pend_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (pend[t*NUM_CORES+s] && !(clr_en && clr_sender == ID_W'(s)
                                      && clr_target == ID_W'(t))) |=> pend[t*NUM_CORES+s]);
      end
   end

endmodule

// File: rtl/ipi_irq_reduce.sv
module ipi_irq_reduce #(
   parameter int NUM_CORES = 4,
   localparam int CELLS    = NUM_CORES * NUM_CORES
) (
   input  logic [CELLS-1:0]     pend,
   output logic [NUM_CORES-1:0] irq
);

   for (genvar t = 0; t < NUM_CORES; t++) begin : g_line
      assign irq[t] = |pend[t*NUM_CORES +: NUM_CORES];
   end

endmodule

// File: rtl/ipi_readback.sv
module ipi_readback
   import ipi_pkg::*;
#(
   parameter int NUM_CORES = 4,
   parameter int ID_W      = (NUM_CORES > 1) ? $clog2(NUM_CORES) : 1,
   localparam int CELLS    = NUM_CORES * NUM_CORES
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 cmd_valid,
   input  ipi_op_e              cmd_op,
   input  logic [ID_W-1:0]      cmd_core,
   input  logic [ID_W-1:0]      cmd_arg,
   input  logic [CELLS-1:0]     pend,
   output logic [NUM_CORES-1:0] rb_data
);

   logic [NUM_CORES-1:0] rb_next;
   logic                 pair_bit;

   assign pair_bit = pend[int'(cmd_arg)*NUM_CORES + int'(cmd_core)];

   always_comb begin
      rb_next = '0;
      unique case (cmd_op)
         IPI_OP_STATUS:  rb_next[0] = pair_bit;
         IPI_OP_SOURCES: rb_next    = pend[int'(cmd_core)*NUM_CORES +: NUM_CORES];
         default:        rb_next    = '0;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         rb_data <= '0;
      else if (cmd_valid) rb_data <= rb_next;
   end

   // R3
   rb_status_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_valid && cmd_op == IPI_OP_STATUS && pair_bit) |=> (rb_data == NUM_CORES'(1)));
   // R10
   rb_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !cmd_valid |=> $stable(rb_data));
   // R10
   rb_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_valid && (cmd_op == IPI_OP_RAISE || cmd_op == IPI_OP_ACK)) |=> (rb_data == '0));

endmodule

// File: rtl/ipi_unit.sv
module ipi_unit
   import ipi_pkg::*;
#(
   parameter int NUM_CORES = 4,
   localparam int ID_W     = (NUM_CORES > 1) ? $clog2(NUM_CORES) : 1,
   localparam int CELLS    = NUM_CORES * NUM_CORES
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 cmd_valid,
   input  logic [ID_W-1:0]      cmd_core,
   input  logic [1:0]           cmd_op,
   input  logic [ID_W-1:0]      cmd_arg,
   output logic [NUM_CORES-1:0] rb_data,
   output logic [NUM_CORES-1:0] irq_out
);

   if (NUM_CORES < 2 || NUM_CORES > 32) begin : g_bad_cfg
      $error("ipi_unit: NUM_CORES must lie in 2..32");
   end

   ipi_op_e          op;
   logic             raise_en, ack_en;
   logic [CELLS-1:0] pend;

   assign op       = ipi_op_e'(cmd_op);
   assign raise_en = cmd_valid && (op == IPI_OP_RAISE);
   assign ack_en   = cmd_valid && (op == IPI_OP_ACK);

   ipi_pend_matrix #(.NUM_CORES(NUM_CORES), .ID_W(ID_W)) u_matrix (
      .clk        (clk),
      .rst_n      (rst_n),
      .set_en     (raise_en),
      .set_sender (cmd_core),
      .set_target (cmd_arg),
      .clr_en     (ack_en),
      .clr_sender (cmd_arg),
      .clr_target (cmd_core),
      .pend       (pend)
   );

   ipi_irq_reduce #(.NUM_CORES(NUM_CORES)) u_reduce (
      .pend (pend),
      .irq  (irq_out)
   );

   ipi_readback #(.NUM_CORES(NUM_CORES), .ID_W(ID_W)) u_rb (
      .clk       (clk),
      .rst_n     (rst_n),
      .cmd_valid (cmd_valid),
      .cmd_op    (op),
      .cmd_core  (cmd_core),
      .cmd_arg   (cmd_arg),
      .pend      (pend),
      .rb_data   (rb_data)
   );

   // R2
   irq_raise_chk: assert property (@(posedge clk) disable iff (!rst_n)
      raise_en |=> irq_out[$past(cmd_arg)]);
   // R11
   idle_irq_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !cmd_valid |=> $stable(irq_out));

   for (genvar t = 0; t < NUM_CORES; t++) begin : g_line_chk
      // R6
      irq_fall_by_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
         $fell(irq_out[t]) |-> $past(ack_en && cmd_core == ID_W'(t)));
   end

endmodule

// File: tb/tb_ipi_unit.sv
module tb_ipi_unit;

   localparam int N = 4;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         cmd_valid = 1'b0;
   logic [1:0]   cmd_core = '0;
   logic [1:0]   cmd_op = '0;
   logic [1:0]   cmd_arg = '0;
   logic [N-1:0] rb_data;
   logic [N-1:0] irq_out;

   int checks = 0;
   int errors = 0;
   logic [N-1:0] m [N];   // m[target][sender]
   logic [N-1:0] rb_exp;

   always #2 clk = ~clk;

   ipi_unit #(.NUM_CORES(N)) dut (
      .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_core(cmd_core),
      .cmd_op(cmd_op), .cmd_arg(cmd_arg), .rb_data(rb_data), .irq_out(irq_out)
   );

   function automatic logic [N-1:0] irq_model();
      logic [N-1:0] v;
      for (int t = 0; t < N; t++) v[t] = |m[t];
      return v;
   endfunction

   task automatic check(input string tag, input logic [N-1:0] act, input logic [N-1:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   // issue one command at a negedge, sample at the following negedge
   task automatic cmd(input int c, input int op, input int a, input string tag);
      @(negedge clk);
      cmd_valid = 1'b1;
      cmd_core  = 2'(c);
      cmd_op    = 2'(op);
      cmd_arg   = 2'(a);
      case (op)
         0: rb_exp = {{(N-1){1'b0}}, m[a][c]};
         2: rb_exp = m[c];
         default: rb_exp = '0;
      endcase
      if (op == 1) m[a][c] = 1'b1;
      if (op == 3) m[c][a] = 1'b0;
      @(negedge clk);
      cmd_valid = 1'b0;
      check({tag, " readback"}, rb_data, rb_exp);
      check({tag, " irq"}, irq_out, irq_model());
   endtask

   initial begin
      int cyc = 0;
      while (cyc < 100000) begin
         @(posedge clk);
         cyc++;
      end
      errors++;
      $display("FAIL watchdog actual=%0d expected=<100000", cyc);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      logic [N-1:0] held;
      logic [7:0]   lfsr;
      for (int t = 0; t < N; t++) m[t] = '0;
      repeat (3) @(negedge clk);
      // R1 reset state
      check("R1 reset readback", rb_data, '0);
      check("R1 reset irq", irq_out, '0);
      rst_n = 1'b1;
      @(negedge clk);

      // sweep every sender/target pair, including self pairs (R9)
      for (int s = 0; s < N; s++) begin
         for (int t = 0; t < N; t++) begin
            cmd(s, 1, t, (s == t) ? "R9 self raise" : "R2 raise");
            cmd(s, 0, t, "R3 status pending");
            cmd(t, 2, 0, "R4 sources");
            cmd(t, 3, s, "R5 ack");
            cmd(s, 0, t, "R3 status cleared");
            check("R6 line low after last ack", irq_out[t], 1'b0);
         end
      end

      // coalescing on target 1, repeat raise, ordered acks
      for (int s = 0; s < N; s++) cmd(s, 1, 1, "R7 coalesce raise");
      cmd(1, 2, 0, "R7 sources all");
      check("R7 mask full", rb_data, '1);
      cmd(0, 1, 1, "R8 repeat raise");
      cmd(1, 2, 0, "R8 mask unchanged");
      cmd(2, 3, 0, "R5 ack not pending");
      cmd(1, 3, 3, "R6 ack 3");
      check("R6 line held", irq_out[1], 1'b1);
      cmd(1, 3, 0, "R6 ack 0");
      cmd(1, 3, 2, "R6 ack 2");
      check("R6 line held", irq_out[1], 1'b1);
      cmd(1, 3, 1, "R6 ack last");
      check("R6 line dropped", irq_out[1], 1'b0);

      // idle strobe with arbitrary fields: nothing moves
      cmd(2, 1, 3, "R2 raise before idle");
      cmd(3, 2, 0, "R4 sources before idle");
      held = rb_data;
      for (int i = 0; i < 16; i++) begin
         @(negedge clk);
         cmd_core = 2'(i);
         cmd_op   = 2'(i >> 2);
         cmd_arg  = 2'(i + 1);
         @(negedge clk);
         check("R10 readback held", rb_data, held);
         check("R11 irq unchanged", irq_out, irq_model());
      end

      // exhaustive command sweep, then pseudo-random mix against the model
      for (int c = 0; c < N; c++)
         for (int op = 0; op < 4; op++)
            for (int a = 0; a < N; a++)
               cmd(c, op, a, "R3/R4/R5 sweep");
      lfsr = 8'hA5;
      for (int i = 0; i < 400; i++) begin
         lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
         cmd(int'(lfsr[1:0]), int'(lfsr[3:2]), int'(lfsr[5:4]), "R2/R5/R7 mix");
      end

      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule